// File: doc/BRIEF.md
# ATM Cell Delineator with Header Check and Filter

This block sits behind the payload error corrector and descrambler of a downstream receive path. It takes one byte per accepted input beat, with no knowledge of where cells begin, and finds the 53-byte cell grid by testing the header error check at every byte offset. It then confirms the grid over several cells before it trusts it. Once locked, it checks every header. It repairs a lone flipped bit when the previous header was clean, and throws away cells that cannot be trusted, idle filler cells and, optionally, cells whose flow-control and path fields fail a masked compare.

Cells that survive are streamed out byte for byte with a start marker on the first header byte. The output lags the input by five accepted bytes, so the header verdict is known before the first byte leaves. Two free-running counters report delivered cells and cells lost to header errors.

Top module: `cell_delineator`

## Requirements
- R1: The check byte of a header is the CRC-8 of header bytes 0..3, with generator x^8+x^2+x+1, zero preset, most significant bit of byte 0 first, XORed with 0x55. As a worked value, the header 00 00 00 01 carries check byte 0x52.
- R2: In the hunt state every accepted byte ends a candidate 5-byte window. The first window whose check byte is correct fixes the cell grid at that offset and moves the block to the presync state.
- R3: In presync, 6 further consecutive correct headers move the block to sync, and any incorrect header sends it back to hunt. Only cells whose header is judged in sync are delivered or counted.
- R4: In sync, 7 consecutive headers with a nonzero syndrome return the block to hunt. A correct header restarts that run, so 6 bad headers followed by a good one keep the lock.
- R5: A single-bit header error, in bytes 0..3 or in the check byte, is corrected and the cell is delivered with the corrected header, but only when the previous header in sync was error-free. Any header error while the previous header had an error discards the cell.
- R6: A cell in sync whose header is not delivered because of a header error increments the header-drop counter by one.
- R7: A cell whose header bytes 0..3 are 00 00 00 01 is discarded and changes neither counter.
- R8: With the filter enabled, a cell is kept only if ({byte0, byte1[7:4]} AND mask) equals (match AND mask), both 12 bits wide. A cell that fails is discarded without touching either counter. With the filter disabled, the field has no effect.
- R9: A delivered cell leaves as 53 consecutive output bytes in arrival order. The start flag is set only on header byte 0, and at most one output byte follows each accepted input byte.
- R10: After reset both counters read zero and no output is valid. The accept counter increments by one for each delivered cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is valid this cycle |
| in_byte | input | 8 | Corrected, descrambled payload byte |
| filt_en | input | 1 | Enable the masked field filter |
| filt_match | input | 12 | Field value to compare against |
| filt_mask | input | 12 | Bits of the field that take part in the compare |
| cell_valid | output | 1 | Output byte is valid |
| cell_data | output | 8 | Output cell byte |
| cell_sop | output | 1 | Marks header byte 0 of a delivered cell |
| cnt_accepted | output | CNT_W | Delivered cell count |
| cnt_hec_drop | output | CNT_W | Cells dropped for header errors |

## Verification
The stimulus first drops out of presync on a bad header. A design that entered sync too early, or counted drops outside sync, would then deliver or count cells that ought to vanish. Back-to-back single-bit errors target the correction/detection toggle: a design without that memory would deliver the second cell instead of counting it as dropped, and a lone error in the check byte exposes a corrector that only covers bytes 0..3. A run of six bad headers followed by a good one, and then a run of seven, pins the loss threshold, since an off-by-one design either loses lock early or delivers cells after the seventh. Masked and unmasked filter settings, idle cells and a double-bit error confirm that discarded cells leave the counters exactly as specified.

// File: rtl/cell_delin_pkg.sv
`timescale 1ns/1ps
package cell_delin_pkg;
    localparam int CELL_BYTES = 53;
    localparam int HDR_BYTES  = 5;
    localparam int HDR_BITS   = HDR_BYTES * 8;
    localparam int POS_W      = $clog2(CELL_BYTES);
    localparam int FIELD_W    = 12;
    localparam logic [7:0]  HEC_COSET = 8'h55;
    localparam logic [7:0]  CRC_POLY  = 8'h07;
    localparam logic [31:0] IDLE_BODY = 32'h0000_0001;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_PRESYNC = 2'd1,
        ST_SYNC    = 2'd2
    } dl_state_t;

    typedef struct packed {
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
        logic [7:0] b3;
        logic [7:0] hec;
    } cell_hdr_t;

    typedef struct packed {
        logic                clean;
        logic                fixable;
        logic [HDR_BITS-1:0] fixed;
    } hec_result_t;

    // CRC-8 over 32 header bits, zero preset, MSB first
    function automatic logic [7:0] crc8_body(input logic [31:0] d);
        logic [7:0] r;
        logic       fb;
        r = 8'h00;
        for (int k = 31; k >= 0; k--) begin
            fb = r[7] ^ d[k];
            r  = {r[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
        end
        return r;
    endfunction

    // Syndrome contribution of an error pattern (linear part only)
    function automatic logic [7:0] err_syndrome(input logic [HDR_BITS-1:0] e);
        return crc8_body(e[HDR_BITS-1:8]) ^ e[7:0];
    endfunction
endpackage

// File: rtl/cell_hec_check.sv
`timescale 1ns/1ps
module cell_hec_check
    import cell_delin_pkg::*;
(
    input  logic [HDR_BITS-1:0] hdr_in,
    output hec_result_t         res
);
    logic [7:0]          syn;
    logic [HDR_BITS-1:0] flip;

    always_comb begin
        syn  = crc8_body(hdr_in[HDR_BITS-1:8]) ^ HEC_COSET ^ hdr_in[7:0];
        flip = '0;
        for (int i = 0; i < HDR_BITS; i++) begin
            if (syn != 8'h00 && err_syndrome(HDR_BITS'(1) << i) == syn)
                flip[i] = 1'b1;
        end
        res.clean   = (syn == 8'h00);
        res.fixable = (flip != '0);
        res.fixed   = hdr_in ^ flip;
    end
endmodule

// File: rtl/cell_filter.sv
`timescale 1ns/1ps
module cell_filter
    import cell_delin_pkg::*;
(
    input  logic [31:0]        body,
    input  logic               filt_en,
    input  logic [FIELD_W-1:0] filt_match,
    input  logic [FIELD_W-1:0] filt_mask,
    output logic               is_idle,
    output logic               field_ok
);
    logic [FIELD_W-1:0] field;

    always_comb begin
        field    = body[31:32-FIELD_W];
        is_idle  = (body == IDLE_BODY);
        field_ok = !filt_en || ((field & filt_mask) == (filt_match & filt_mask));
    end
endmodule

// File: rtl/cell_sync_fsm.sv
`timescale 1ns/1ps
module cell_sync_fsm
    import cell_delin_pkg::*;
#(
    parameter int PRESYNC_GOOD = 6,
    parameter int SYNC_BAD     = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_en,
    input  logic             hdr_clean,
    output dl_state_t        state,
    output logic [POS_W-1:0] pos,
    output logic             eval,
    output logic             corr_mode
);
    localparam int GOOD_W = $clog2(PRESYNC_GOOD + 1);
    localparam int BAD_W  = $clog2(SYNC_BAD + 1);

    dl_state_t         state_q;
    logic [POS_W-1:0]  pos_q;
    logic [GOOD_W-1:0] good_q;
    logic [BAD_W-1:0]  bad_q;
    logic              corr_q;

    assign state     = state_q;
    assign pos       = pos_q;
    assign corr_mode = corr_q;
    assign eval      = byte_en &&
                       (state_q == ST_HUNT || pos_q == POS_W'(HDR_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
            good_q  <= '0;
            bad_q   <= '0;
            corr_q  <= 1'b1;
        end else if (byte_en) begin
            pos_q <= (pos_q == POS_W'(CELL_BYTES - 1)) ? '0 : pos_q + 1'b1;
            if (eval) begin
                unique case (state_q)
                    ST_HUNT: begin
                        if (hdr_clean) begin
                            state_q <= ST_PRESYNC;
                            pos_q   <= POS_W'(HDR_BYTES);
                            good_q  <= '0;
                        end
                    end
                    ST_PRESYNC: begin
                        if (!hdr_clean) begin
                            state_q <= ST_HUNT;
                        end else if (good_q == GOOD_W'(PRESYNC_GOOD - 1)) begin
                            state_q <= ST_SYNC;
                            bad_q   <= '0;
                            corr_q  <= 1'b1;
                        end else begin
                            good_q <= good_q + 1'b1;
                        end
                    end
                    ST_SYNC: begin
                        corr_q <= hdr_clean;
                        if (hdr_clean) begin
                            bad_q <= '0;
                        end else if (bad_q == BAD_W'(SYNC_BAD - 1)) begin
                            state_q <= ST_HUNT;
                            bad_q   <= '0;
                        end else begin
                            bad_q <= bad_q + 1'b1;
                        end
                    end
                    default: state_q <= ST_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/cell_delineator.sv
`timescale 1ns/1ps
module cell_delineator
    import cell_delin_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int PRESYNC_GOOD = 6,
    parameter int SYNC_BAD     = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [7:0]         in_byte,
    input  logic               filt_en,
    input  logic [FIELD_W-1:0] filt_match,
    input  logic [FIELD_W-1:0] filt_mask,
    output logic               cell_valid,
    output logic [7:0]         cell_data,
    output logic               cell_sop,
    output logic [CNT_W-1:0]   cnt_accepted,
    output logic [CNT_W-1:0]   cnt_hec_drop
);
    logic [7:0]          dly_q [HDR_BYTES];
    logic [HDR_BITS-1:0] win;
    hec_result_t         chk;
    dl_state_t           dl_state;
    logic [POS_W-1:0]    pos;
    logic [POS_W-1:0]    out_idx;
    logic                eval;
    logic                corr_mode;
    logic                is_idle;
    logic                field_ok;
    logic                hdr_usable;
    logic                deliver;
    logic                hec_drop;
    logic                keep_q;
    cell_hdr_t           hdr_q;

    function automatic logic [7:0] pick_hdr(input cell_hdr_t h, input logic [2:0] k);
        case (k)
            3'd0:    return h.b0;
            3'd1:    return h.b1;
            3'd2:    return h.b2;
            3'd3:    return h.b3;
            default: return h.hec;
        endcase
    endfunction

    assign win = {dly_q[3], dly_q[2], dly_q[1], dly_q[0], in_byte};

    cell_hec_check u_hec (
        .hdr_in (win),
        .res    (chk)
    );

    cell_sync_fsm #(
        .PRESYNC_GOOD (PRESYNC_GOOD),
        .SYNC_BAD     (SYNC_BAD)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .byte_en   (in_valid),
        .hdr_clean (chk.clean),
        .state     (dl_state),
        .pos       (pos),
        .eval      (eval),
        .corr_mode (corr_mode)
    );

    cell_filter u_filt (
        .body       (chk.fixed[HDR_BITS-1:8]),
        .filt_en    (filt_en),
        .filt_match (filt_match),
        .filt_mask  (filt_mask),
        .is_idle    (is_idle),
        .field_ok   (field_ok)
    );

    always_comb begin
        hdr_usable = chk.clean || (corr_mode && chk.fixable);
        deliver    = eval && (dl_state == ST_SYNC) && hdr_usable && !is_idle && field_ok;
        hec_drop   = eval && (dl_state == ST_SYNC) && !hdr_usable;
        if (pos >= POS_W'(HDR_BYTES))
            out_idx = pos - POS_W'(HDR_BYTES);
        else
            out_idx = pos + POS_W'(CELL_BYTES - HDR_BYTES);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HDR_BYTES; i++) dly_q[i] <= '0;
            keep_q       <= 1'b0;
            hdr_q        <= '0;
            cell_valid   <= 1'b0;
            cell_sop     <= 1'b0;
            cell_data    <= '0;
            cnt_accepted <= '0;
            cnt_hec_drop <= '0;
        end else begin
            cell_valid <= 1'b0;
            cell_sop   <= 1'b0;
            if (in_valid) begin
                for (int i = HDR_BYTES - 1; i > 0; i--) dly_q[i] <= dly_q[i-1];
                dly_q[0] <= in_byte;
                if (keep_q) begin
                    cell_valid <= 1'b1;
                    cell_sop   <= (out_idx == '0);
                    cell_data  <= (out_idx < POS_W'(HDR_BYTES)) ?
                                  pick_hdr(hdr_q, out_idx[2:0]) : dly_q[HDR_BYTES-1];
                end
                if (eval) begin
                    keep_q <= deliver;
                    if (deliver) hdr_q <= cell_hdr_t'(chk.fixed);
                end
                if (deliver)  cnt_accepted <= cnt_accepted + 1'b1;
                if (hec_drop) cnt_hec_drop <= cnt_hec_drop + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cell_delin_chk.sv
`timescale 1ns/1ps
module cell_delin_chk
    import cell_delin_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             cell_valid,
    input logic             cell_sop,
    input logic [CNT_W-1:0] cnt_accepted,
    input logic [CNT_W-1:0] cnt_hec_drop,
    input dl_state_t        dl_state
);
    logic [POS_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else if (cell_valid)
            beat_q <= (beat_q == POS_W'(CELL_BYTES - 1)) ? '0 : beat_q + 1'b1;
    end

    AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (rst)
        cell_valid |-> $past(in_valid)); // R9
    AST_SOP_ON_CELL_GRID: assert property (@(posedge clk) disable iff (rst)
        cell_valid |-> (cell_sop == (beat_q == '0))); // R9
    AST_NO_STRAY_SOP: assert property (@(posedge clk) disable iff (rst)
        !cell_valid |-> !cell_sop); // R9
    AST_ACCEPT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_accepted != $past(cnt_accepted)) |-> (cnt_accepted == $past(cnt_accepted) + 1'b1)); // R10
    AST_ACCEPT_ONLY_SYNC: assert property (@(posedge clk) disable iff (rst)
        (cnt_accepted != $past(cnt_accepted)) |-> ($past(dl_state) == ST_SYNC)); // R3
    AST_DROP_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_hec_drop != $past(cnt_hec_drop)) |-> (cnt_hec_drop == $past(cnt_hec_drop) + 1'b1)); // R6
    AST_DROP_ONLY_SYNC: assert property (@(posedge clk) disable iff (rst)
        (cnt_hec_drop != $past(cnt_hec_drop)) |-> ($past(dl_state) == ST_SYNC)); // R6
    AST_NO_HUNT_TO_SYNC: assert property (@(posedge clk) disable iff (rst)
        (dl_state == ST_SYNC) |-> ($past(dl_state) != ST_HUNT)); // R3
endmodule

bind cell_delineator cell_delin_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .cell_valid   (cell_valid),
    .cell_sop     (cell_sop),
    .cnt_accepted (cnt_accepted),
    .cnt_hec_drop (cnt_hec_drop),
    .dl_state     (dl_state)
);

// File: tb/cell_delineator_test.sv
`timescale 1ns/1ps
module cell_delineator_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        filt_en = 1'b0;
    logic [11:0] filt_match = 12'h000;
    logic [11:0] filt_mask = 12'h000;
    logic        cell_valid;
    logic [7:0]  cell_data;
    logic        cell_sop;
    logic [15:0] cnt_accepted;
    logic [15:0] cnt_hec_drop;

    always #2.5 clk = ~clk;

    cell_delineator #(.CNT_W(16)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .filt_en(filt_en), .filt_match(filt_match), .filt_mask(filt_mask),
        .cell_valid(cell_valid), .cell_data(cell_data), .cell_sop(cell_sop),
        .cnt_accepted(cnt_accepted), .cnt_hec_drop(cnt_hec_drop)
    );

    typedef struct { logic [8:0] v; string tag; } exp_t;
    exp_t exp_q[$];
    int n_cmp = 0, n_bad = 0, exp_acc = 0, exp_drop = 0, gap_ctr = 0;
    bit done = 0;

    function automatic logic [7:0] ref_hec(input logic [31:0] body); // R1
        logic [7:0] r;
        logic       t;
        r = 8'h00;
        for (int k = 31; k >= 0; k--) begin
            t = r[7] ^ body[k];
            r = r << 1;
            if (t) r = r ^ 8'h07;
        end
        return r ^ 8'h55;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        gap_ctr++;
        if (gap_ctr % 11 == 0) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic send_cell(input string tag, input logic [31:0] body, input logic [39:0] err,
                             input logic [7:0] seed, input bit zero_cell,
                             input bit exp_deliver, input bit exp_hdrop);
        logic [39:0] h, tx;
        exp_t e;
        h  = zero_cell ? 40'h0 : {body, ref_hec(body)};
        tx = zero_cell ? 40'h0 : (h ^ err);
        if (exp_deliver) begin
            for (int k = 0; k < 5; k++) begin
                e.v = {k == 0, h[39-8*k -: 8]};
                e.tag = tag;
                exp_q.push_back(e);
            end
            for (int k = 0; k < 48; k++) begin
                e.v = {1'b0, 8'(seed + 8'(k))};
                e.tag = tag;
                exp_q.push_back(e);
            end
            exp_acc++;
        end
        if (exp_hdrop) exp_drop++;
        for (int k = 0; k < 5; k++) put_byte(tx[39-8*k -: 8]);
        for (int k = 0; k < 48; k++) put_byte(zero_cell ? 8'h00 : 8'(seed + 8'(k)));
        check({tag, " accept counter (R10)"}, 32'(cnt_accepted), 32'(exp_acc));
        check({tag, " header drop counter (R6)"}, 32'(cnt_hec_drop), 32'(exp_drop));
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: scoreboard compare of delivered bytes
    always @(negedge clk) begin
        if (!rst && cell_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R9 unexpected byte actual=%0h expected=none", {cell_sop, cell_data});
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " delivered byte {sop,data} (R9)"}, 32'({cell_sop, cell_data}), 32'(e.v));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R10 reset valid", 32'(cell_valid), 0);
        check("R10 reset accept", 32'(cnt_accepted), 0);
        check("R10 reset drop", 32'(cnt_hec_drop), 0);
        rst = 1'b0;
        check("R1 idle header check byte", 32'(ref_hec(32'h0000_0001)), 32'h52);

        // R2 hunt through junk, then R3 fall back from presync on a bad header
        repeat (17) put_byte(8'h00);
        send_cell("R2", 32'h0000_0020, 40'h0, 8'h10, 0, 0, 0);
        send_cell("R3", 32'h0000_0020, 40'h0, 8'h20, 0, 0, 0);
        send_cell("R3", 32'h0000_0020, 40'h0, 8'h30, 0, 0, 0);
        send_cell("R3", 32'h0, 40'h0, 8'h00, 1, 0, 0);
        repeat (5) put_byte(8'h00);
        send_cell("R2", 32'h0000_0020, 40'h0, 8'h40, 0, 0, 0);
        for (int i = 0; i < 6; i++)
            send_cell("R3", 32'h0000_0020, 40'h0, 8'(8'h50 + 8'(i)), 0, 0, 0);

        // in sync: delivery, idle, correction and detection
        send_cell("R9", 32'h1234_5670, 40'h0, 8'h80, 0, 1, 0);
        send_cell("R7", 32'h0000_0001, 40'h0, 8'h90, 0, 0, 0);
        send_cell("R5", 32'hABCD_EF10, 40'h00_0400_0000, 8'hA0, 0, 1, 0);
        send_cell("R5", 32'hABCD_EF20, 40'h00_0400_0000, 8'hB0, 0, 0, 1);
        send_cell("R9", 32'h5555_AAA0, 40'h0, 8'hC0, 0, 1, 0);
        send_cell("R5", 32'h0F0F_0F00, 40'h00_0000_0001, 8'hD0, 0, 1, 0);
        send_cell("R9", 32'h7777_7770, 40'h0, 8'hE0, 0, 1, 0);
        send_cell("R6", 32'h2222_2220, 40'h80_0000_0001, 8'hF0, 0, 0, 1);
        send_cell("R9", 32'h3333_3330, 40'h0, 8'h05, 0, 1, 0);

        // R8 filter
        filt_en = 1'b1; filt_match = 12'h123; filt_mask = 12'hFF0;
        send_cell("R8", 32'h12A0_0040, 40'h0, 8'h15, 0, 1, 0);
        send_cell("R8", 32'h1330_0040, 40'h0, 8'h25, 0, 0, 0);
        filt_mask = 12'hFFF; filt_match = 12'h133;
        send_cell("R8", 32'h1330_0050, 40'h0, 8'h35, 0, 1, 0);
        send_cell("R8", 32'h1320_0050, 40'h0, 8'h45, 0, 0, 0);
        filt_en = 1'b0;
        send_cell("R8", 32'h1320_0060, 40'h0, 8'h55, 0, 1, 0);

        // R4 loss threshold
        for (int i = 0; i < 6; i++) send_cell("R4", 32'h0, 40'h0, 8'h00, 1, 0, 1);
        send_cell("R4", 32'h4444_4440, 40'h0, 8'h65, 0, 1, 0);
        for (int i = 0; i < 7; i++) send_cell("R4", 32'h0, 40'h0, 8'h00, 1, 0, 1);
        repeat (11) put_byte(8'h00);
        send_cell("R4", 32'h0000_0020, 40'h0, 8'h70, 0, 0, 0);
        for (int i = 0; i < 6; i++)
            send_cell("R3", 32'h0000_0020, 40'h0, 8'(8'h75 + 8'(i)), 0, 0, 0);
        send_cell("R4", 32'h6666_6660, 40'h0, 8'h85, 0, 1, 0);
        send_cell("R7", 32'h0000_0001, 40'h0, 8'h95, 0, 0, 0);

        @(negedge clk);
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        check("R9 all expected bytes delivered", 32'(exp_q.size()), 0);
        done = 1;
        report();
    end
endmodule